// File: doc/BRIEF.md
# One-Wire Bus Reset and Presence Detector

This block is the bus-master side of the initialization handshake on a single open-drain one-wire line. Software writes a start bit. The block then pulls the line low for the reset interval and releases it. At one fixed point inside the window where an attached slave answers, it samples the line and stores the result as a presence flag. When the sequence has run its full length, the block clears the start bit by itself. A presence flag of 1 means at least one slave answered. Working out how many slaves there are is left to software.

All intervals are counted in ticks of a programmable prescaler, which is meant to be set for one microsecond. With the default counts, the line is driven low for 480 ticks. The sample is taken 68 ticks after release, and the sequence ends 512 ticks after release. The block never drives the line high. It only asserts a drive-low enable. The line input passes through a two-flop synchronizer before it is used.

The sequencer is a four-state machine:
- `ST_IDLE`: the line is released.
- `ST_RESET_LOW`: the line is driven low.
- `ST_WAIT_SAMPLE`: the line is released and the block is waiting for the sample tick.
- `ST_TAIL`: the line is released and the block is waiting for the end tick.

Its transitions are:
- **launch**: `ST_IDLE` to `ST_RESET_LOW` on an accepted start write.
- **release**: `ST_RESET_LOW` to `ST_WAIT_SAMPLE` on the last reset tick.
- **sample**: `ST_WAIT_SAMPLE` to `ST_TAIL` on the sample tick, which also latches presence.
- **finish**: `ST_TAIL` to `ST_IDLE` on the end tick.

Top module: `owrp_ctrl`

## Requirements
- R1: After reset the line drive-low output is 0. Register 0 bit 0 (start/busy) reads 0, register 1 bit 0 (presence) reads 0, and register 2 reads the parameter PRESC_RESET.
- R2: A write to address 0 with data bit 0 set, while idle, starts a sequence: the drive-low output is 1 from the next clock. A write to address 0 with bit 0 clear has no effect.
- R3: Register 2 (bits 7:0, read/write) sets the tick period to (value+1) clocks. The tick count restarts at the start of each sequence.
- R4: The drive-low output stays 1 for exactly RESET_US ticks, which is RESET_US*(value+1) clocks, and then returns to 0.
- R5: SAMPLE_US ticks after release, presence is set to 1 if the synchronized line is low, and to 0 otherwise. The synchronized value at that edge is the line input as it stood at the clock edge two cycles earlier.
- R6: Presence is cleared to 0 when a sequence starts. It changes at no other time except the sample of R5.
- R7: Register 0 bit 0 reads 1 from the start until DONE_US ticks after release, and then clears by itself. After release, the line is not driven again within that sequence.
- R8: A start write while a sequence is running is ignored: the timing of the running sequence does not change.
- R9: Address 3 reads 0, and all unused bits of registers 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for writes and reads |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| line_drive_low_o | output | 1 | Open-drain enable; 1 pulls the line low |
| line_i | input | 1 | Line level as seen at the pad |

## Verification
The bench builds the block with PRESC_RESET=3, RESET_US=24, SAMPLE_US=7 and DONE_US=16. This keeps a full sequence to a few hundred clocks, so many slave-response windows fit into one run. It also reprograms the prescaler to 1 and 0. Because the tick is then only one or two clocks long, the sample point can be hit from either side by a single clock, which exposes the synchronizer's two-cycle latency and the exclusive end of a presence pulse. The short reset interval also makes it cheap to fire a second start write in the middle of the low phase and to confirm the exact low length.

// File: rtl/owrp_pkg.sv
package owrp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_RESET_LOW   = 2'd1,
        ST_WAIT_SAMPLE = 2'd2,
        ST_TAIL        = 2'd3
    } owrp_state_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_PRESC = 2'd2;

endpackage

// File: rtl/owrp_prescaler.sv
module owrp_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               restart_i,
    input  logic               enable_i,
    input  logic [PRESC_W-1:0] div_i,
    output logic               tick_o
);

    logic [PRESC_W-1:0] cnt_q;
    logic               wrap;

    // wrap also covers a divisor lowered below the current count mid-run
    assign wrap   = (cnt_q >= div_i);
    assign tick_o = enable_i && wrap && !restart_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (enable_i) begin
            if (wrap) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/owrp_sync.sv
module owrp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // released line idles high, so the chain resets to ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/owrp_regs.sv
module owrp_regs
    import owrp_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int PRESC_W     = 8,
    parameter int PRESC_RESET = 99
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [1:0]         addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    input  logic               busy_i,
    input  logic               presence_i,
    output logic               start_req_o,
    output logic [PRESC_W-1:0] presc_o
);

    localparam logic [PRESC_W-1:0] PRESC_INIT = PRESC_W'(PRESC_RESET);

    logic [PRESC_W-1:0] presc_q;

    assign start_req_o = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[0];
    assign presc_o     = presc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            presc_q <= PRESC_INIT;
        end else if (wr_en_i && (addr_i == ADDR_PRESC)) begin
            presc_q <= wdata_i[PRESC_W-1:0];
        end
    end

    always_comb begin
        unique case (addr_i)
            ADDR_CTRL:  rdata_o = {{(REG_W-1){1'b0}}, busy_i};
            ADDR_STAT:  rdata_o = {{(REG_W-1){1'b0}}, presence_i};
            ADDR_PRESC: rdata_o = REG_W'(presc_q);
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/owrp_seq.sv
module owrp_seq
    import owrp_pkg::*;
#(
    parameter int RESET_US  = 480,
    parameter int SAMPLE_US = 68,
    parameter int DONE_US   = 512
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_req_i,
    input  logic tick_i,
    input  logic line_sync_i,
    output logic start_acc_o,
    output logic busy_o,
    output logic drive_low_o,
    output logic presence_o
);

    localparam int CNT_MAX = (RESET_US > DONE_US) ? RESET_US : DONE_US;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RESET_LAST  = CNT_W'(RESET_US - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_US - 1);
    localparam logic [CNT_W-1:0] DONE_LAST   = CNT_W'(DONE_US - 1);

    owrp_state_e      state_q, state_d;
    logic [CNT_W-1:0] tick_cnt_q;
    logic             presence_q;
    logic             launch, release_ev, sample_ev, finish_ev;

    assign launch     = (state_q == ST_IDLE) && start_req_i;
    assign release_ev = (state_q == ST_RESET_LOW) && tick_i && (tick_cnt_q == RESET_LAST);
    assign sample_ev  = (state_q == ST_WAIT_SAMPLE) && tick_i && (tick_cnt_q == SAMPLE_LAST);
    assign finish_ev  = (state_q == ST_TAIL) && tick_i && (tick_cnt_q == DONE_LAST);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (launch)     state_d = ST_RESET_LOW;
            ST_RESET_LOW:   if (release_ev) state_d = ST_WAIT_SAMPLE;
            ST_WAIT_SAMPLE: if (sample_ev)  state_d = ST_TAIL;
            ST_TAIL:        if (finish_ev)  state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // tick counter: counts reset ticks, then ticks since release
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tick_cnt_q <= '0;
        end else if (launch || release_ev || finish_ev) begin
            tick_cnt_q <= '0;
        end else if (tick_i && (state_q != ST_IDLE)) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // presence flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            presence_q <= 1'b0;
        end else if (launch) begin
            presence_q <= 1'b0;
        end else if (sample_ev) begin
            presence_q <= !line_sync_i;
        end
    end

    // outputs
    always_comb begin
        start_acc_o = launch;
        presence_o  = presence_q;
        unique case (state_q)
            ST_IDLE: begin
                busy_o      = 1'b0;
                drive_low_o = 1'b0;
            end
            ST_RESET_LOW: begin
                busy_o      = 1'b1;
                drive_low_o = 1'b1;
            end
            ST_WAIT_SAMPLE, ST_TAIL: begin
                busy_o      = 1'b1;
                drive_low_o = 1'b0;
            end
            default: begin
                busy_o      = 1'b0;
                drive_low_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/owrp_ctrl.sv
module owrp_ctrl
    import owrp_pkg::*;
#(
    parameter int PRESC_RESET = 99,
    parameter int RESET_US    = 480,
    parameter int SAMPLE_US   = 68,
    parameter int DONE_US     = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       reg_wr_en_i,
    input  logic [1:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       line_drive_low_o,
    input  logic       line_i
);

    localparam int REG_W   = 8;
    localparam int PRESC_W = 8;

    logic               start_req;
    logic               start_acc;
    logic               busy;
    logic               presence;
    logic               tick;
    logic               line_sync;
    logic [PRESC_W-1:0] presc;

    owrp_regs #(
        .REG_W       (REG_W),
        .PRESC_W     (PRESC_W),
        .PRESC_RESET (PRESC_RESET)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (reg_wr_en_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .busy_i      (busy),
        .presence_i  (presence),
        .start_req_o (start_req),
        .presc_o     (presc)
    );

    owrp_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (start_acc),
        .enable_i  (busy),
        .div_i     (presc),
        .tick_o    (tick)
    );

    owrp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (line_i),
        .sync_o  (line_sync)
    );

    owrp_seq #(
        .RESET_US  (RESET_US),
        .SAMPLE_US (SAMPLE_US),
        .DONE_US   (DONE_US)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_req_i (start_req),
        .tick_i      (tick),
        .line_sync_i (line_sync),
        .start_acc_o (start_acc),
        .busy_o      (busy),
        .drive_low_o (line_drive_low_o),
        .presence_o  (presence)
    );

endmodule

// File: rtl/owrp_checker.sv
module owrp_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       reg_wr_en_i,
    input logic [1:0] reg_addr_i,
    input logic [7:0] reg_wdata_i,
    input logic       drive_low,
    input logic       busy,
    input logic       presence
);

    logic start_write;
    assign start_write = reg_wr_en_i && (reg_addr_i == 2'd0) && reg_wdata_i[0];

    AST_LAUNCH_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_write && !busy) |=> drive_low) else $error("launch"); // R2

    AST_LAUNCH_CLEARS_PST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_write && !busy) |=> !presence) else $error("pst clear"); // R6

    AST_PST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && !start_write) |=> $stable(presence)) else $error("pst hold"); // R6

    AST_NO_REDRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && !drive_low) |=> !drive_low) else $error("redrive"); // R7

    AST_DRIVE_WITHIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_low |-> busy) else $error("drive idle"); // R7

    AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && drive_low && start_write) |=> busy) else $error("busy start"); // R8

endmodule

bind owrp_ctrl owrp_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_en_i (reg_wr_en_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .drive_low   (line_drive_low_o),
    .busy        (busy),
    .presence    (presence)
);

// File: tb/owrp_ctrl_tb.sv
module owrp_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int P_RESET    = 3;
    localparam int R_US       = 24;
    localparam int S_US       = 7;
    localparam int D_US       = 16;
    localparam int WATCHDOG   = 100000;

    // presc, pulse start clock, pulse end clock (exclusive, relative to release), expected presence
    typedef struct packed {
        logic [7:0]  presc;
        logic [15:0] p_start;
        logic [15:0] p_end;
        logic        exp_pst;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{8'd3, 16'd0,  16'd0,  1'b0},
        '{8'd3, 16'd10, 16'd40, 1'b1},
        '{8'd3, 16'd27, 16'd60, 1'b0},
        '{8'd3, 16'd26, 16'd60, 1'b1},
        '{8'd3, 16'd5,  16'd26, 1'b0},
        '{8'd3, 16'd5,  16'd27, 1'b1},
        '{8'd1, 16'd12, 16'd30, 1'b1},
        '{8'd1, 16'd13, 16'd30, 1'b0},
        '{8'd0, 16'd2,  16'd6,  1'b1},
        '{8'd0, 16'd6,  16'd9,  1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       drive_low;
    logic       slave_low = 1'b0;
    logic       line;

    int checks = 0;
    int failures = 0;

    assign line = !(drive_low || slave_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    owrp_ctrl #(
        .PRESC_RESET (P_RESET),
        .RESET_US    (R_US),
        .SAMPLE_US   (S_US),
        .DONE_US     (D_US)
    ) u_dut (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .reg_wr_en_i      (reg_wr_en),
        .reg_addr_i       (reg_addr),
        .reg_wdata_i      (reg_wdata),
        .reg_rdata_o      (reg_rdata),
        .line_drive_low_o (drive_low),
        .line_i           (line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // runs a sequence already launched; returns low length, busy length after release, presence
    task automatic run_seq(input int ps, input int pe, input int mid_write,
                           output int low_cnt, output int busy_cnt, output int pst);
        logic [7:0] rd;
        low_cnt = 0;
        while (drive_low && low_cnt < 5000) begin
            low_cnt++;
            if (low_cnt == mid_write) begin
                reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'd1;
            end else begin
                reg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        busy_cnt = 0;
        for (int c = 1; c < 5000; c++) begin
            slave_low = (c >= ps) && (c < pe);
            reg_read(2'd0, rd);
            if (!rd[0]) break;
            busy_cnt++;
            @(negedge clk);
        end
        slave_low = 1'b0;
        reg_read(2'd1, rd);
        pst = rd[0];
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int low_cnt, busy_cnt, pst, per;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(drive_low == 1'b0, "R1 drive", drive_low, 0);
        reg_read(2'd0, rd); check(rd == 8'd0, "R1 busy", rd, 0);
        reg_read(2'd1, rd); check(rd == 8'd0, "R1 pst", rd, 0);
        reg_read(2'd2, rd); check(rd == 8'(P_RESET), "R1 presc", rd, P_RESET);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: address 3 reads zero
        reg_read(2'd3, rd); check(rd == 8'd0, "R9 addr3", rd, 0);

        // R2: writing 0 to the start bit does nothing
        reg_write(2'd0, 8'd0);
        repeat (5) @(negedge clk);
        check(drive_low == 1'b0, "R2 zero write drive", drive_low, 0);
        reg_read(2'd0, rd); check(rd == 8'd0, "R2 zero write busy", rd, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            per = int'(VECS[i].presc) + 1;
            reg_write(2'd2, VECS[i].presc);
            reg_read(2'd2, rd);
            check(rd == VECS[i].presc, "R3 presc readback", rd, VECS[i].presc);
            reg_write(2'd0, 8'd1);
            check(drive_low == 1'b1, "R2 launch", drive_low, 1);
            reg_read(2'd1, rd);
            check(rd == 8'd0, "R6 pst cleared at start", rd, 0);
            reg_read(2'd0, rd);
            check(rd == 8'd1, "R7 busy at start", rd, 1);
            run_seq(int'(VECS[i].p_start), int'(VECS[i].p_end), 0, low_cnt, busy_cnt, pst);
            check(low_cnt == R_US * per, "R4 low length", low_cnt, R_US * per);
            check(busy_cnt == D_US * per, "R7 busy after release", busy_cnt, D_US * per);
            check(pst == int'(VECS[i].exp_pst), "R5 presence", pst, VECS[i].exp_pst);
            // R6: presence holds while idle
            repeat (4) @(negedge clk);
            reg_read(2'd1, rd);
            check(rd[0] == VECS[i].exp_pst, "R6 pst hold", rd[0], VECS[i].exp_pst);
            check(drive_low == 1'b0, "R7 released when idle", drive_low, 0);
        end

        // R8: start write during the low phase is ignored
        reg_write(2'd2, 8'd3);
        reg_write(2'd0, 8'd1);
        run_seq(10, 40, 20, low_cnt, busy_cnt, pst);
        check(low_cnt == R_US * 4, "R8 low length unchanged", low_cnt, R_US * 4);
        check(busy_cnt == D_US * 4, "R8 busy length unchanged", busy_cnt, D_US * 4);
        check(pst == 1, "R8 presence", pst, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule